// File: doc/BRIEF.md
# Post-update load/store address unit

This execute-stage unit serves 64-bit fixed-point loads and stores whose base register is updated *after* the memory access. A decoded operation comes in on a single-cycle valid/ready handshake. It carries the access size, the load/store direction, the sign-extension choice, the offset form, the base, index and source register values, the immediate, and the base and target register indices. The unit sends exactly one memory request addressed by the unmodified base value. It then reports completion with the new base value (base plus offset) and, for loads, the size-adjusted load result.

The offset is one of three kinds. It is a sign-extended 16-bit immediate, or a 14-bit field scaled by four and sign-extended, or the index register value. A load whose base index is zero or equal to its target index is an invalid form. For such a load the unit issues no memory request, raises an illegal flag and suppresses both writebacks. Loaded data is taken as right-aligned. Alignment, byte order and caching belong to the surrounding pipeline.

Top module: `postinc_lsu`

## Requirements
- R1: The memory request address equals the base value (`ra_val_i`) sampled when the operation was accepted, not base plus offset. Later changes on the operand inputs have no effect.
- R2: On completion of a legal operation `ra_data_o` equals accepted base plus offset. Form code 00 uses the sign-extended 16-bit `imm_i`. Form codes 10 and 11 use `rb_val_i`.
- R3: Form code 01 uses an offset of `imm_i[13:0]` with two zero bits appended on the right, then sign-extended to 64 bits. The offset is therefore always a multiple of 4.
- R4: Size codes are 00 byte, 01 halfword, 10 word and 11 doubleword, and the code is driven on `mem_size_o`. An unsigned load returns the low 8/16/32 bits of `mem_rdata_i` with all higher bits cleared. A doubleword load returns all 64 bits unchanged.
- R5: With `op_signed_i`=1, halfword and word loads sign-extend the loaded value to 64 bits. The flag has no effect on byte loads (still zero-filled) or doubleword loads.
- R6: A store drives `mem_we_o`=1 and sends the low 8/16/32/64 bits of RS on `mem_wdata_o` with higher bits cleared. `done_o` rises in the cycle after the request handshake, with `ra_we_o`=1 and `rt_we_o`=0.
- R7: After a load request is accepted, `done_o` rises in the cycle after `mem_rsp_valid_i`, with `rt_we_o` and `ra_we_o` both 1. `done_o` lasts one cycle.
- R8: A load with base index 0 or base index equal to target index issues no request. In the cycle after acceptance it raises `done_o` and `illegal_o` with both writebacks low. Stores with base index 0 are legal.
- R9: While `mem_req_valid_o`=1 and `mem_req_ready_i`=0, the request stays valid and its address, data, size and direction hold steady.
- R10: `op_ready_o` is 1 only while no operation is in flight. After reset, `op_ready_o`=1 and `mem_req_valid_o`, `done_o` and all writebacks are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid_i | input | 1 | Decoded operation present |
| op_ready_o | output | 1 | Unit can accept an operation |
| op_size_i | input | 2 | Access size code |
| op_store_i | input | 1 | 1 store, 0 load |
| op_signed_i | input | 1 | Sign-extend halfword/word loads |
| op_form_i | input | 2 | Offset form: 00 immediate, 01 scaled field, 1x index register |
| ra_val_i | input | 64 | Base register value |
| rb_val_i | input | 64 | Index register value |
| rs_val_i | input | 64 | Store source value |
| imm_i | input | 16 | Immediate field |
| ra_idx_i | input | IDX_W | Base register index |
| rt_idx_i | input | IDX_W | Target register index |
| mem_req_valid_o | output | 1 | Memory request valid |
| mem_req_ready_i | input | 1 | Memory accepts request |
| mem_addr_o | output | 64 | Access address |
| mem_we_o | output | 1 | 1 write, 0 read |
| mem_size_o | output | 2 | Access size code |
| mem_wdata_o | output | 64 | Right-aligned store data |
| mem_rsp_valid_i | input | 1 | Load data valid |
| mem_rdata_i | input | 64 | Right-aligned load data |
| done_o | output | 1 | One-cycle completion pulse |
| rt_we_o | output | 1 | Target register write enable |
| rt_data_o | output | 64 | Target register value |
| ra_we_o | output | 1 | Base register write enable |
| ra_data_o | output | 64 | Updated base value |
| illegal_o | output | 1 | Invalid form flagged |

## Verification
The request becomes visible one cycle after the operation handshake. A store completes one cycle after its request handshake, a load one cycle after its response pulse, and an invalid load one cycle after acceptance. The bench's reference model advances at each rising edge on the same handshakes, with its own offset and extension arithmetic. Every handshake, request field and completion field is compared at the following falling edge, so each result is checked in exactly the cycle it is due. Ready and response delays of zero and several cycles are both driven, and the operand inputs are scrambled after acceptance.

// File: rtl/pu_pkg.sv
package pu_pkg;
  parameter int unsigned XLEN  = 64;
  parameter int unsigned IMM_W = 16;
  parameter int unsigned DSF_W = 14;

  typedef logic [XLEN-1:0] word_t;

  typedef enum logic [1:0] {SZ_B = 2'b00, SZ_H = 2'b01, SZ_W = 2'b10, SZ_D = 2'b11} size_e;
  typedef enum logic [1:0] {FM_D = 2'b00, FM_DS = 2'b01, FM_X = 2'b10, FM_X2 = 2'b11} form_e;

  // Offset added to the base after the access.
  function automatic word_t pu_offset(form_e f, logic [IMM_W-1:0] imm, word_t rb);
    word_t r;
    unique case (f)
      FM_D:    r = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
      FM_DS:   r = {{(XLEN-DSF_W-2){imm[DSF_W-1]}}, imm[DSF_W-1:0], 2'b00};
      default: r = rb;
    endcase
    return r;
  endfunction

  // Mask of the lanes a store of this size writes.
  function automatic word_t pu_lanes(size_e s);
    word_t r;
    unique case (s)
      SZ_B:    r = {{(XLEN-8){1'b0}},  {8{1'b1}}};
      SZ_H:    r = {{(XLEN-16){1'b0}}, {16{1'b1}}};
      SZ_W:    r = {{(XLEN-32){1'b0}}, {32{1'b1}}};
      default: r = {XLEN{1'b1}};
    endcase
    return r;
  endfunction

  // Load result shaping; byte always zero-fills.
  function automatic word_t pu_extend(size_e s, logic sgn, word_t raw);
    word_t r;
    unique case (s)
      SZ_B:    r = {{(XLEN-8){1'b0}}, raw[7:0]};
      SZ_H:    r = {{(XLEN-16){sgn & raw[15]}}, raw[15:0]};
      SZ_W:    r = {{(XLEN-32){sgn & raw[31]}}, raw[31:0]};
      default: r = raw;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/pu_addr_calc.sv
module pu_addr_calc
  import pu_pkg::*;
(
  input  logic [1:0]       form_i,
  input  logic [IMM_W-1:0] imm_i,
  input  word_t            base_i,
  input  word_t            index_i,
  output word_t            access_o,
  output word_t            base_next_o
);
  word_t offset;
  assign offset      = pu_offset(form_e'(form_i), imm_i, index_i);
  assign access_o    = base_i;
  assign base_next_o = base_i + offset;
endmodule

// File: rtl/pu_load_shape.sv
module pu_load_shape
  import pu_pkg::*;
(
  input  logic [1:0] size_i,
  input  logic       signed_i,
  input  word_t      raw_i,
  output word_t      result_o
);
  assign result_o = pu_extend(size_e'(size_i), signed_i, raw_i);
endmodule

// File: rtl/pu_seq.sv
module pu_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic op_valid_i,
  input  logic op_bad_i,
  input  logic st_q_i,
  input  logic req_ready_i,
  input  logic rsp_valid_i,
  output logic op_ready_o,
  output logic req_valid_o,
  output logic done_o,
  output logic op_accept_o,
  output logic req_fire_o,
  output logic rsp_take_o
);
  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT, S_DONE} state_e;
  state_e state_q, state_d;

  assign op_ready_o  = (state_q == S_IDLE);
  assign req_valid_o = (state_q == S_REQ);
  assign done_o      = (state_q == S_DONE);
  assign op_accept_o = op_ready_o & op_valid_i;
  assign req_fire_o  = req_valid_o & req_ready_i;
  assign rsp_take_o  = (state_q == S_WAIT) & rsp_valid_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE: if (op_accept_o) state_d = op_bad_i ? S_DONE : S_REQ;
      S_REQ:  if (req_fire_o)  state_d = st_q_i ? S_DONE : S_WAIT;
      S_WAIT: if (rsp_take_o)  state_d = S_DONE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= S_IDLE;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/postinc_lsu.sv
module postinc_lsu #(
  parameter int unsigned IDX_W = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      op_valid_i,
  output logic                      op_ready_o,
  input  logic [1:0]                op_size_i,
  input  logic                      op_store_i,
  input  logic                      op_signed_i,
  input  logic [1:0]                op_form_i,
  input  logic [pu_pkg::XLEN-1:0]   ra_val_i,
  input  logic [pu_pkg::XLEN-1:0]   rb_val_i,
  input  logic [pu_pkg::XLEN-1:0]   rs_val_i,
  input  logic [pu_pkg::IMM_W-1:0]  imm_i,
  input  logic [IDX_W-1:0]          ra_idx_i,
  input  logic [IDX_W-1:0]          rt_idx_i,
  output logic                      mem_req_valid_o,
  input  logic                      mem_req_ready_i,
  output logic [pu_pkg::XLEN-1:0]   mem_addr_o,
  output logic                      mem_we_o,
  output logic [1:0]                mem_size_o,
  output logic [pu_pkg::XLEN-1:0]   mem_wdata_o,
  input  logic                      mem_rsp_valid_i,
  input  logic [pu_pkg::XLEN-1:0]   mem_rdata_i,
  output logic                      done_o,
  output logic                      rt_we_o,
  output logic [pu_pkg::XLEN-1:0]   rt_data_o,
  output logic                      ra_we_o,
  output logic [pu_pkg::XLEN-1:0]   ra_data_o,
  output logic                      illegal_o
);
  import pu_pkg::*;

  // Named internal events, also observed by the bound checker.
  logic  op_accept, req_fire, rsp_take, op_bad;
  word_t access_addr, base_next, shaped;

  logic  st_q, sgn_q, bad_q;
  logic [1:0] size_q;
  word_t addr_q, ra_new_q, wdata_q, rt_q;

  assign op_bad = ~op_store_i & ((ra_idx_i == '0) | (ra_idx_i == rt_idx_i));

  pu_addr_calc u_addr (
    .form_i      (op_form_i),
    .imm_i       (imm_i),
    .base_i      (ra_val_i),
    .index_i     (rb_val_i),
    .access_o    (access_addr),
    .base_next_o (base_next)
  );

  pu_load_shape u_shape (
    .size_i   (size_q),
    .signed_i (sgn_q),
    .raw_i    (mem_rdata_i),
    .result_o (shaped)
  );

  pu_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_valid_i  (op_valid_i),
    .op_bad_i    (op_bad),
    .st_q_i      (st_q),
    .req_ready_i (mem_req_ready_i),
    .rsp_valid_i (mem_rsp_valid_i),
    .op_ready_o  (op_ready_o),
    .req_valid_o (mem_req_valid_o),
    .done_o      (done_o),
    .op_accept_o (op_accept),
    .req_fire_o  (req_fire),
    .rsp_take_o  (rsp_take)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= 1'b0;
      sgn_q    <= 1'b0;
      bad_q    <= 1'b0;
      size_q   <= 2'b00;
      addr_q   <= '0;
      ra_new_q <= '0;
      wdata_q  <= '0;
    end else if (op_accept) begin
      st_q     <= op_store_i;
      sgn_q    <= op_signed_i;
      bad_q    <= op_bad;
      size_q   <= op_size_i;
      addr_q   <= access_addr;
      ra_new_q <= base_next;
      wdata_q  <= op_store_i ? (rs_val_i & pu_lanes(size_e'(op_size_i))) : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rt_q <= '0;
    else if (rsp_take) rt_q <= shaped;
  end

  assign mem_addr_o  = addr_q;
  assign mem_we_o    = st_q;
  assign mem_size_o  = size_q;
  assign mem_wdata_o = wdata_q;
  assign ra_data_o   = ra_new_q;
  assign rt_data_o   = rt_q;
  assign illegal_o   = done_o & bad_q;
  assign ra_we_o     = done_o & ~bad_q;
  assign rt_we_o     = done_o & ~bad_q & ~st_q;
endmodule

// File: rtl/pu_chk.sv
module pu_chk #(
  parameter int unsigned XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            op_ready_o,
  input logic [XLEN-1:0] ra_val_i,
  input logic            mem_req_valid_o,
  input logic            mem_req_ready_i,
  input logic [XLEN-1:0] mem_addr_o,
  input logic [XLEN-1:0] mem_wdata_o,
  input logic            mem_we_o,
  input logic [1:0]      mem_size_o,
  input logic            done_o,
  input logic            ra_we_o,
  input logic            rt_we_o,
  input logic            illegal_o,
  input logic [XLEN-1:0] rt_data_o,
  input logic            st_q,
  input logic [1:0]      size_q,
  input logic            op_accept,
  input logic            req_fire,
  input logic            rsp_take
);
  assert_addr_is_base_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req_valid_o) |-> (mem_addr_o == $past(ra_val_i)));

  assert_byte_zero_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rt_we_o && size_q == 2'b00) |-> (rt_data_o[XLEN-1:8] == '0));

  assert_store_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_fire && st_q) |=> (done_o && ra_we_o && !rt_we_o));

  assert_load_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_take |=> (done_o && rt_we_o && ra_we_o));

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_illegal_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> (!ra_we_o && !rt_we_o && $past(op_accept)));

  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid_o && !mem_req_ready_i) |=> (mem_req_valid_o && $stable(mem_addr_o)
      && $stable(mem_wdata_o) && $stable(mem_we_o) && $stable(mem_size_o)));

  assert_idle_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    op_ready_o |-> (!mem_req_valid_o && !done_o));
endmodule

bind postinc_lsu pu_chk #(.XLEN(pu_pkg::XLEN)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .op_ready_o      (op_ready_o),
  .ra_val_i        (ra_val_i),
  .mem_req_valid_o (mem_req_valid_o),
  .mem_req_ready_i (mem_req_ready_i),
  .mem_addr_o      (mem_addr_o),
  .mem_wdata_o     (mem_wdata_o),
  .mem_we_o        (mem_we_o),
  .mem_size_o      (mem_size_o),
  .done_o          (done_o),
  .ra_we_o         (ra_we_o),
  .rt_we_o         (rt_we_o),
  .illegal_o       (illegal_o),
  .rt_data_o       (rt_data_o),
  .st_q            (st_q),
  .size_q          (size_q),
  .op_accept       (op_accept),
  .req_fire        (req_fire),
  .rsp_take        (rsp_take)
);

// File: tb/tb_postinc_lsu.sv
`timescale 1ns/1ps
module tb_postinc_lsu;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic op_valid, op_ready, op_store, op_signed, req_valid, req_ready, we, rsp_valid;
  logic done, rt_we, ra_we, illegal;
  logic [1:0] op_size, op_form, msize;
  logic [63:0] ra_val, rb_val, rs_val, addr, wdata, rdata, rt_data, ra_data;
  logic [15:0] imm;
  logic [4:0] ra_idx, rt_idx;

  postinc_lsu #(.IDX_W(5)) dut (
    .clk(clk), .rst_n(rst_n), .op_valid_i(op_valid), .op_ready_o(op_ready),
    .op_size_i(op_size), .op_store_i(op_store), .op_signed_i(op_signed), .op_form_i(op_form),
    .ra_val_i(ra_val), .rb_val_i(rb_val), .rs_val_i(rs_val), .imm_i(imm),
    .ra_idx_i(ra_idx), .rt_idx_i(rt_idx), .mem_req_valid_o(req_valid), .mem_req_ready_i(req_ready),
    .mem_addr_o(addr), .mem_we_o(we), .mem_size_o(msize), .mem_wdata_o(wdata),
    .mem_rsp_valid_i(rsp_valid), .mem_rdata_i(rdata), .done_o(done), .rt_we_o(rt_we),
    .rt_data_o(rt_data), .ra_we_o(ra_we), .ra_data_o(ra_data), .illegal_o(illegal));

  int checks = 0, failures = 0, cycles = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Independent arithmetic for the expected values.
  function automatic logic [63:0] ref_off(logic [1:0] f, logic [15:0] im, logic [63:0] rb);
    longint v;
    if (f == 2'b00)      v = longint'($signed(im));
    else if (f == 2'b01) v = longint'($signed(im[13:0])) * 4;
    else                 v = longint'(rb);
    return 64'(v);
  endfunction

  function automatic logic [63:0] ref_ext(logic [1:0] sz, bit sg, logic [63:0] raw);
    int sh = 64 - (8 << sz);
    logic [63:0] up = raw << sh;
    if (sg && (sz == 2'b01 || sz == 2'b10)) return 64'($signed(up) >>> sh);
    return up >> sh;
  endfunction

  // Behavioural reference: 0 idle, 1 request, 2 await data, 3 complete.
  int m_ph;
  logic [63:0] m_addr, m_ra, m_rt, m_wd;
  logic [1:0] m_sz, m_form;
  bit m_st, m_sg, m_bad;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_ph <= 0;
    else begin
      case (m_ph)
        0: if (op_valid) begin
          bit b;
          b = !op_store && (ra_idx == 0 || ra_idx == rt_idx);
          m_bad <= b; m_st <= op_store; m_sg <= op_signed; m_sz <= op_size; m_form <= op_form;
          m_addr <= ra_val; m_ra <= ra_val + ref_off(op_form, imm, rb_val);
          m_wd <= op_store ? (rs_val & ((op_size == 2'b11) ? ~64'd0 : ((64'd1 << (8 << op_size)) - 1))) : 64'd0;
          m_ph <= b ? 3 : 1;
        end
        1: if (req_ready) m_ph <= m_st ? 3 : 2;
        2: if (rsp_valid) begin m_rt <= ref_ext(m_sz, m_sg, rdata); m_ph <= 3; end
        default: m_ph <= 0;
      endcase
    end
  end

  always @(negedge clk) if (rst_n) begin
    chk(op_ready == (m_ph == 0), "R10 op_ready", 64'(op_ready), 64'(m_ph == 0));
    chk(req_valid == (m_ph == 1), m_bad ? "R8 no request" : "R9 request valid", 64'(req_valid), 64'(m_ph == 1));
    chk(done == (m_ph == 3), m_st ? "R6 store done" : "R7 done timing", 64'(done), 64'(m_ph == 3));
    if (m_ph == 1) begin
      chk(addr == m_addr, "R1 address is old base", addr, m_addr);
      chk(we == m_st, "R6 write enable", 64'(we), 64'(m_st));
      chk(msize == m_sz, "R4 size code", 64'(msize), 64'(m_sz));
      chk(wdata == m_wd, "R6 store data", wdata, m_wd);
    end
    if (m_ph == 3) begin
      chk(illegal == m_bad, "R8 illegal flag", 64'(illegal), 64'(m_bad));
      chk(ra_we == !m_bad, "R8 base write enable", 64'(ra_we), 64'(!m_bad));
      chk(rt_we == (!m_bad && !m_st), m_st ? "R6 no target write" : "R7 target write", 64'(rt_we), 64'(!m_bad && !m_st));
      if (!m_bad) chk(ra_data == m_ra, m_form == 2'b01 ? "R3 scaled offset" : "R2 base update", ra_data, m_ra);
      if (!m_bad && !m_st) chk(rt_data == m_rt, m_sg ? "R5 signed load" : "R4 load result", rt_data, m_rt);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic run(input logic [1:0] sz, input bit st, input bit sg, input logic [1:0] fm,
                     input logic [63:0] ra, input logic [63:0] rb, input logic [63:0] rs,
                     input logic [15:0] im, input logic [4:0] ai, input logic [4:0] ti,
                     input int rdy_dly, input int rsp_dly, input logic [63:0] rd);
    bit bad = !st && (ai == 0 || ai == ti);
    op_size = sz; op_store = st; op_signed = sg; op_form = fm; ra_val = ra; rb_val = rb;
    rs_val = rs; imm = im; ra_idx = ai; rt_idx = ti; op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
    // Scramble operands after acceptance (R1: latched values only).
    ra_val = ~ra; rb_val = ~rb; rs_val = ~rs; imm = ~im; op_size = ~sz; op_signed = ~sg;
    if (bad) begin
      repeat (3) @(negedge clk);
      return;
    end
    repeat (rdy_dly) @(negedge clk);
    req_ready = 1'b1;
    @(negedge clk);
    req_ready = 1'b0;
    if (!st) begin
      repeat (rsp_dly) @(negedge clk);
      rsp_valid = 1'b1; rdata = rd;
      @(negedge clk);
      rsp_valid = 1'b0; rdata = 64'hDEAD_BEEF_0BAD_F00D;
    end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    op_valid = 0; op_size = 0; op_store = 0; op_signed = 0; op_form = 0; ra_val = 0; rb_val = 0;
    rs_val = 0; imm = 0; ra_idx = 0; rt_idx = 0; req_ready = 0; rsp_valid = 0; rdata = 0;
    repeat (2) @(negedge clk);
    // R10: reset state
    chk(op_ready == 1'b1, "R10 reset ready", 64'(op_ready), 64'd1);
    chk(req_valid == 1'b0, "R10 reset request", 64'(req_valid), 64'd0);
    chk(done == 1'b0 && ra_we == 1'b0 && rt_we == 1'b0, "R10 reset done/writebacks", 64'(done), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 R2 R4: byte load, negative immediate
    run(2'b00, 0, 0, 2'b00, 64'h1000, 64'h0, 64'h0, 16'hFFF0, 5'd3, 5'd4, 0, 0, 64'hFFFF_FFFF_FFFF_FFAB);
    // R5: signed flag has no effect on byte
    run(2'b00, 0, 1, 2'b00, 64'h2000, 64'h0, 64'h0, 16'h0010, 5'd3, 5'd4, 2, 1, 64'h0000_0000_0000_0080);
    run(2'b01, 0, 0, 2'b10, 64'h3000, 64'h40, 64'h0, 16'h0, 5'd5, 5'd6, 0, 3, 64'h1234_5678_9ABC_8001);
    run(2'b01, 0, 1, 2'b10, 64'h3000, 64'hFFFF_FFFF_FFFF_FFF8, 64'h0, 16'h0, 5'd5, 5'd6, 1, 0, 64'h1234_5678_9ABC_8001);
    run(2'b10, 0, 0, 2'b00, 64'h4000, 64'h0, 64'h0, 16'h7FFF, 5'd7, 5'd8, 0, 0, 64'hAAAA_AAAA_8000_0000);
    run(2'b10, 0, 1, 2'b11, 64'h4000, 64'h100, 64'h0, 16'h0, 5'd7, 5'd8, 3, 2, 64'hAAAA_AAAA_8000_0000);
    // R3: scaled offset, negative and positive
    run(2'b11, 0, 1, 2'b01, 64'h5000, 64'h0, 64'h0, 16'h3FFF, 5'd9, 5'd1, 0, 0, 64'hFEDC_BA98_7654_3210);
    run(2'b11, 0, 0, 2'b01, 64'h5000, 64'h0, 64'h0, 16'hC005, 5'd9, 5'd1, 1, 1, 64'h8000_0000_0000_0001);
    // R6: stores of every size, base index 0 legal for stores
    run(2'b00, 1, 0, 2'b00, 64'h6000, 64'h0, 64'h1122_3344_5566_7788, 16'h0001, 5'd0, 5'd0, 0, 0, 64'h0);
    run(2'b01, 1, 0, 2'b10, 64'h6100, 64'h8, 64'h1122_3344_5566_7788, 16'h0, 5'd2, 5'd2, 4, 0, 64'h0);
    run(2'b10, 1, 1, 2'b01, 64'h6200, 64'h0, 64'h1122_3344_5566_7788, 16'h0002, 5'd2, 5'd9, 1, 0, 64'h0);
    run(2'b11, 1, 0, 2'b00, 64'h6300, 64'h0, 64'h1122_3344_5566_7788, 16'h8000, 5'd2, 5'd9, 0, 0, 64'h0);
    // R8: invalid load forms
    run(2'b00, 0, 0, 2'b00, 64'h7000, 64'h0, 64'h0, 16'h4, 5'd0, 5'd4, 0, 0, 64'h0);
    run(2'b11, 0, 0, 2'b10, 64'h7000, 64'h8, 64'h0, 16'h0, 5'd12, 5'd12, 0, 0, 64'h0);
    // Back-to-back legal load after invalid ones
    run(2'b01, 0, 1, 2'b00, 64'h8000, 64'h0, 64'h0, 16'h0002, 5'd31, 5'd30, 2, 2, 64'h0000_0000_0000_7FFF);
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule